// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream from a three-wire serial port and turns it into parallel samples. The three wires are a bit clock, a frame clock and a data line. All three are oversampled in the system clock domain: the block finds bit-clock edges itself and never uses the bit clock as a clock. Each decoded channel sample appears on its own 24-bit output, left-aligned, and comes with a one-cycle strobe.

A 3-bit format code selects one of eight framings. Every framing uses a fixed 64-bit frame. The framings differ in three ways: where the word sits inside its 32-bit half, which frame-clock level marks the left channel, and which bit-clock edge samples the data. If the code changes while the block is running, the receiver flushes its state and hunts for a fresh frame boundary before it produces any more samples.

The control logic is a three-state machine:
- `ST_FLUSH` clears the shift register and bit counter for one cycle.
- `ST_HUNT` waits for a frame marker and emits nothing. The marker is any frame-clock transition in the framed formats, or a rising sync pulse in DSP format.
- `ST_RUN` emits samples.

The transitions are:
- `FLUSH→HUNT` always, after one cycle.
- `HUNT→RUN` on the first marker.
- `RUN→RUN` while the code is unchanged.
- `any→FLUSH` on reset or on a change of the format code.

Top module: `sai_rx_top`

## Requirements
- R1: While reset is asserted and after its release, both words read zero and both strobes are low until a sample has been decoded.
- R2: Format code mapping: 0, 1, 2 are right-justified with 16, 20, 24-bit words. 3, 4, 5 are I2S with 16, 20, 24-bit words. 6 is left-justified 16-bit. 7 is DSP 16-bit.
- R3: Every frame is 64 bit clocks long, split into two 32-bit halves, with data sent MSB first. In right-justified formats the word's LSB is the last bit of its half, and the word starts N bits before the frame-clock edge.
- R4: In right-justified and left-justified formats the half with the frame clock high is the left channel. In I2S the half with the frame clock low is the left channel.
- R5: In I2S the MSB is the second bit of the half, one bit clock after the frame-clock edge. In left-justified format the MSB is the first bit of the half.
- R6: Codes 0 to 6 sample data and frame clock on the rising bit-clock edge. Code 7 samples them on the falling edge.
- R7: In DSP format the frame clock is high for exactly one bit. The next 16 bits are the left word and the 16 bits after that are the right word, MSB first. The remaining 31 bits of the frame have no effect on either output.
- R8: Words shorter than 24 bits are output left-aligned: the MSB is at bit 23 and the unused low bits are zero.
- R9: Each channel strobe pulses exactly once per frame. A word changes only in the cycle its strobe is high, and the two strobes are never high together.
- R10: After a change of the format code, no strobe is produced in the next cycle. No strobe is produced for any half that started before a new frame marker was seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | Serial bit clock |
| fclk_in | input | 1 | Frame clock or DSP sync pulse |
| sdata_in | input | 1 | Serial data line |
| fmt_sel | input | 3 | Framing format code (see R2) |
| left_word | output | 24 | Last left sample, left-aligned |
| left_stb | output | 1 | One-cycle pulse when left_word updates |
| right_word | output | 24 | Last right sample, left-aligned |
| right_stb | output | 1 | One-cycle pulse when right_word updates |

## Verification
Each format is driven with different left and right values, so each of the following faults shows up as a wrong word:
- Swapped I2S polarity exchanges the left and right words.
- An off-by-one MSB position in I2S or left-justified format shifts the word by one bit.
- Counting the right-justified start from the wrong end returns padding instead of data.

DSP frames carry non-zero junk after the right word. A receiver that keeps shifting past bit 32 would therefore corrupt the right word. A receiver that sampled on the wrong edge would read each bit half a bit late.

A format change is made mid-frame, just before a frame-clock edge. A receiver without the flush-and-hunt behaviour would emit a strobe carrying a half-decoded word at that edge.

// File: rtl/sai_rx_pkg.sv
`timescale 1ns/1ps
package sai_rx_pkg;

    // Framing families selected by the format code.
    typedef enum logic [1:0] {
        FAM_RJ,
        FAM_I2S,
        FAM_LJ,
        FAM_DSP
    } fam_e;

    // Receiver control states.
    typedef enum logic [1:0] {
        ST_FLUSH,
        ST_HUNT,
        ST_RUN
    } state_e;

    typedef struct packed {
        fam_e       fam;
        logic [4:0] wlen;
    } fmt_t;

    // Word length used by the DSP framing (left word, then right word).
    localparam int DSP_LEN = 16;

endpackage

// File: rtl/sai_rx_sync.sv
`timescale 1ns/1ps
module sai_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= d_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = pipe[STAGES-1];

endmodule

// File: rtl/sai_rx_fmt_dec.sv
`timescale 1ns/1ps
module sai_rx_fmt_dec
    import sai_rx_pkg::*;
(
    input  logic [2:0] code,
    output fmt_t       fmt
);

    always_comb begin
        unique case (code)
            3'd0:    fmt = '{fam: FAM_RJ,  wlen: 5'd16};
            3'd1:    fmt = '{fam: FAM_RJ,  wlen: 5'd20};
            3'd2:    fmt = '{fam: FAM_RJ,  wlen: 5'd24};
            3'd3:    fmt = '{fam: FAM_I2S, wlen: 5'd16};
            3'd4:    fmt = '{fam: FAM_I2S, wlen: 5'd20};
            3'd5:    fmt = '{fam: FAM_I2S, wlen: 5'd24};
            3'd6:    fmt = '{fam: FAM_LJ,  wlen: 5'd16};
            default: fmt = '{fam: FAM_DSP, wlen: 5'd16};
        endcase
    end

endmodule

// File: rtl/sai_rx_top.sv
`timescale 1ns/1ps
module sai_rx_top
    import sai_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OUT_W       = 24,
    parameter int SLOT_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_in,
    input  logic             fclk_in,
    input  logic             sdata_in,
    input  logic [2:0]       fmt_sel,
    output logic [OUT_W-1:0] left_word,
    output logic             left_stb,
    output logic [OUT_W-1:0] right_word,
    output logic             right_stb
);

    localparam int CNT_W = $clog2(2 * SLOT_W) + 1;
    localparam logic [CNT_W-1:0] L_END   = CNT_W'(DSP_LEN);
    localparam logic [CNT_W-1:0] R_END   = CNT_W'(2 * DSP_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Line synchronisation and edge detection
    logic [2:0] sync_o;
    logic       bclk_s, fclk_s, sdata_s, bclk_d;

    sai_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({bclk_in, fclk_in, sdata_in}),
        .q_out (sync_o)
    );

    assign {bclk_s, fclk_s, sdata_s} = sync_o;

    // Format tracking
    logic [2:0] fmt_q;
    fmt_t       fmt;
    logic       mode_chg;

    sai_rx_fmt_dec u_dec (
        .code (fmt_q),
        .fmt  (fmt)
    );

    assign mode_chg = (fmt_sel != fmt_q);

    // Sampling and frame markers
    state_e            state, state_nxt;
    logic              sample, fclk_prev, frame_edge, sync_start, marker;
    logic              left_half;
    logic [SLOT_W-1:0] shreg, shreg_nxt, shifted;
    logic [CNT_W-1:0]  cnt, cnt_inc;
    logic [OUT_W-1:0]  mask, half_word, dsp_word;
    logic              unused_lo;

    assign sample     = (fmt.fam == FAM_DSP) ? (bclk_d & ~bclk_s) : (~bclk_d & bclk_s);
    assign frame_edge = sample && (fclk_s != fclk_prev);
    assign sync_start = sample && fclk_s && !fclk_prev;
    assign marker     = (fmt.fam == FAM_DSP) ? sync_start : frame_edge;
    assign left_half  = (fmt.fam == FAM_I2S) ? !fclk_prev : fclk_prev;
    assign shreg_nxt  = {shreg[SLOT_W-2:0], sdata_s};
    assign cnt_inc    = cnt + 1'b1;

    // Word extraction from a completed 32-bit half (first bit at the top).
    always_comb begin
        unique case (fmt.fam)
            FAM_RJ:  shifted = shreg << (SLOT_W - int'(fmt.wlen));
            FAM_I2S: shifted = shreg << 1;
            default: shifted = shreg;
        endcase
    end

    assign mask      = {OUT_W{1'b1}} << (OUT_W - int'(fmt.wlen));
    assign half_word = shifted[SLOT_W-1 -: OUT_W] & mask;
    assign unused_lo = ^shifted[SLOT_W-OUT_W-1:0];
    assign dsp_word  = {shreg_nxt[DSP_LEN-1:0], {(OUT_W-DSP_LEN){1'b0}}};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FLUSH;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FLUSH: state_nxt = ST_HUNT;
            ST_HUNT:  if (marker) state_nxt = ST_RUN;
            ST_RUN:   state_nxt = ST_RUN;
            default:  state_nxt = ST_FLUSH;
        endcase
        if (mode_chg) state_nxt = ST_FLUSH;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_d     <= 1'b0;
            fclk_prev  <= 1'b0;
            fmt_q      <= '0;
            shreg      <= '0;
            cnt        <= '0;
            left_word  <= '0;
            right_word <= '0;
            left_stb   <= 1'b0;
            right_stb  <= 1'b0;
        end else begin
            bclk_d    <= bclk_s;
            fmt_q     <= fmt_sel;
            left_stb  <= 1'b0;
            right_stb <= 1'b0;
            if (sample) fclk_prev <= fclk_s;
            if (state == ST_FLUSH || mode_chg) begin
                shreg <= '0;
                cnt   <= '0;
            end else if (sample) begin
                shreg <= shreg_nxt;
                if (sync_start)          cnt <= '0;
                else if (cnt != CNT_MAX) cnt <= cnt_inc;
                if (state == ST_RUN) begin
                    if (fmt.fam == FAM_DSP) begin
                        if (!sync_start && cnt_inc == L_END) begin
                            left_word <= dsp_word;
                            left_stb  <= 1'b1;
                        end
                        if (!sync_start && cnt_inc == R_END) begin
                            right_word <= dsp_word;
                            right_stb  <= 1'b1;
                        end
                    end else if (frame_edge) begin
                        if (left_half) begin
                            left_word <= half_word;
                            left_stb  <= 1'b1;
                        end else begin
                            right_word <= half_word;
                            right_stb  <= 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sai_rx_chk.sv
`timescale 1ns/1ps
module sai_rx_chk #(
    parameter int OUT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       fmt_sel,
    input logic [OUT_W-1:0] left_word,
    input logic             left_stb,
    input logic [OUT_W-1:0] right_word,
    input logic             right_stb
);

    localparam int PAD = OUT_W - 16;

    assert_left_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !left_stb |-> $stable(left_word));

    assert_right_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !right_stb |-> $stable(right_word));

    assert_stb_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_stb && right_stb));

    assert_quiet_after_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fmt_sel) |=> (!left_stb && !right_stb));

    assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (left_stb && $stable(fmt_sel) &&
         (fmt_sel == 3'd0 || fmt_sel == 3'd3 || fmt_sel == 3'd6 || fmt_sel == 3'd7))
        |-> (left_word[PAD-1:0] == '0));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!left_stb && !right_stb);
        end
    end

endmodule

bind sai_rx_top sai_rx_chk #(.OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_sel    (fmt_sel),
    .left_word  (left_word),
    .left_stb   (left_stb),
    .right_word (right_word),
    .right_stb  (right_stb)
);

// File: tb/sai_rx_top_tb_top.sv
`timescale 1ns/1ps
module sai_rx_top_tb_top;

    typedef struct packed {
        logic [2:0]  mode;
        logic [23:0] lv;
        logic [23:0] rv;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 24'hA5C3E1, 24'h3C5A96},
        '{3'd0, 24'h00B7D2, 24'h004E19},
        '{3'd1, 24'h0C3A5F, 24'h0F1E2D},
        '{3'd3, 24'h00C001, 24'h00700E},
        '{3'd4, 24'h08F0A3, 24'h0135C7},
        '{3'd5, 24'h912345, 24'h6ABCDE},
        '{3'd6, 24'h00D00B, 24'h002BB4},
        '{3'd7, 24'h00E371, 24'h00819C},
        '{3'd5, 24'h800001, 24'h7FFFFE},
        '{3'd0, 24'h00FFFF, 24'h008001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0;
    logic        fclk_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic [23:0] left_word, right_word;
    logic        left_stb, right_stb;

    int tests = 0;
    int fails = 0;
    int lcnt = 0;
    int rcnt = 0;

    always #2.5 clk = ~clk;

    sai_rx_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_in    (bclk_in),
        .fclk_in    (fclk_in),
        .sdata_in   (sdata_in),
        .fmt_sel    (fmt_sel),
        .left_word  (left_word),
        .left_stb   (left_stb),
        .right_word (right_word),
        .right_stb  (right_stb)
    );

    always @(negedge clk) begin
        if (left_stb)  lcnt++;
        if (right_stb) rcnt++;
    end

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int wl(input logic [2:0] m);
        case (m)
            3'd1, 3'd4: return 20;
            3'd2, 3'd5: return 24;
            default:    return 16;
        endcase
    endfunction

    function automatic logic [23:0] expect_word(input logic [2:0] m, input logic [23:0] v);
        int n = wl(m);
        logic [23:0] msk = 24'hFFFFFF >> (24 - n);
        return (v & msk) << (24 - n);
    endfunction

    // Builds data and frame-clock bits in send order (index 0 sent first).
    function automatic void build(input logic [2:0] m, input logic [23:0] l, input logic [23:0] r,
                                  output logic [63:0] fd, output logic [63:0] ff);
        int n = wl(m);
        fd = '0;
        ff = '0;
        for (int p = 0; p < 64; p++) begin
            int q = p % 32;
            logic [23:0] v = (p < 32) ? l : r;
            if (m <= 3'd2) begin
                ff[p] = (p < 32);
                if (q >= 32 - n) fd[p] = v[31 - q];
            end else if (m <= 3'd5) begin
                ff[p] = (p >= 32);
                if (q >= 1 && q <= n) fd[p] = v[n - q];
            end else if (m == 3'd6) begin
                ff[p] = (p < 32);
                if (q < n) fd[p] = v[n - 1 - q];
            end else begin
                ff[p] = (p == 0);
                if (p >= 1 && p <= 16)       fd[p] = l[16 - p];
                else if (p >= 17 && p <= 32) fd[p] = r[32 - p];
                else if (p > 32)             fd[p] = p[0] ^ p[2];
            end
        end
    endfunction

    // One bit period of 8 system clocks; data changes on the non-sampling edge.
    task automatic send_bit(input logic [2:0] m, input logic f, input logic d);
        if (m == 3'd7) begin
            bclk_in = 1'b1; fclk_in = f; sdata_in = d;
            repeat (4) @(negedge clk);
            bclk_in = 1'b0;
            repeat (4) @(negedge clk);
        end else begin
            bclk_in = 1'b0; fclk_in = f; sdata_in = d;
            repeat (4) @(negedge clk);
            bclk_in = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 24'h0, 24'h1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] fd, ff;
        logic [2:0]  m;
        int lb, rb, l0, r0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(left_word == 24'h0 && !left_stb, "R1 left in reset", left_word, 24'h0);
        chk(right_word == 24'h0 && !right_stb, "R1 right in reset", right_word, 24'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(left_word == 24'h0, "R1 left after release", left_word, 24'h0);
        chk(lcnt == 0 && rcnt == 0, "R1 no strobe after release", 24'(lcnt + rcnt), 24'h0);

        // Vector table: two frames per entry plus one leading bit of a third.
        for (int i = 0; i < NV; i++) begin
            string tag;
            m = VECS[i].mode;
            fmt_sel = m;
            repeat (10) @(negedge clk);
            build(m, VECS[i].lv, VECS[i].rv, fd, ff);
            lb = 0;
            rb = 0;
            for (int p = 0; p < 129; p++) begin
                send_bit(m, ff[p % 64], fd[p % 64]);
                if (p == 64) begin
                    lb = lcnt;
                    rb = rcnt;
                end
            end
            repeat (4) @(negedge clk);
            if (m <= 3'd2)      tag = "R2 R3 R4 R6 R8";
            else if (m <= 3'd5) tag = "R2 R4 R5 R6 R8";
            else if (m == 3'd6) tag = "R2 R4 R5 R6 R8";
            else                tag = "R2 R6 R7 R8";
            chk(left_word == expect_word(m, VECS[i].lv), $sformatf("%s left mode %0d", tag, m),
                left_word, expect_word(m, VECS[i].lv));
            chk(right_word == expect_word(m, VECS[i].rv), $sformatf("%s right mode %0d", tag, m),
                right_word, expect_word(m, VECS[i].rv));
            chk(lcnt - lb == 1, $sformatf("R9 left strobes per frame mode %0d", m),
                24'(lcnt - lb), 24'h1);
            chk(rcnt - rb == 1, $sformatf("R9 right strobes per frame mode %0d", m),
                24'(rcnt - rb), 24'h1);
        end

        // R10: format switch mid-half suppresses the next frame-clock edge.
        fmt_sel = 3'd2;
        repeat (10) @(negedge clk);
        build(3'd2, 24'h123456, 24'h654321, fd, ff);
        for (int p = 0; p < 80; p++) send_bit(3'd2, ff[p % 64], fd[p % 64]);
        l0 = lcnt;
        r0 = rcnt;
        fmt_sel = 3'd0;
        repeat (10) @(negedge clk);
        for (int p = 80; p < 104; p++) send_bit(3'd0, ff[p % 64], fd[p % 64]);
        chk(lcnt == l0, "R10 no left strobe after switch", 24'(lcnt - l0), 24'h0);
        chk(rcnt == r0, "R10 no right strobe after switch", 24'(rcnt - r0), 24'h0);

        // R1: reset mid-run clears the words.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(left_word == 24'h0 && right_word == 24'h0, "R1 words cleared by reset",
            left_word | right_word, 24'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule